// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces raster timing for one pixel clock domain: a pixel counter inside each 8-pixel character, a character counter along the line and a line counter down the frame. From these it derives display-enable, horizontal sync and vertical sync. Software sets the timing through a small 32-bit register port. Four timing registers describe the two axes. A control register starts and stops the generator and can freeze the timing registers against writes. A read-only register reports the line being scanned.

Horizontal values are given in character units, stored as count minus one. The sync widths sit in the upper half-word of their registers. Each sync register also carries a polarity bit. Timing values that software writes are held in a staging copy. The counters use a working copy, and the staging copy moves into it only at a frame boundary, so a frame never mixes two timings. While the generator is stopped, the working copy follows the staging copy on every cycle.

Top module: `crtc_timing_gen`

## Requirements
- R1: After reset every register reads 0, all counters are 0, and display-enable, hsync and vsync are low.
- R2: While enabled, the pixel-in-character count steps 0 to 7 once per clock. The character count advances when the pixel count is 7 and returns to 0 after the character whose index equals the horizontal total field, which is bits 8:0 of address 0.
- R3: The line count advances by one each time the character count wraps. It returns to 0 after the line whose index equals the vertical total field, which is bits 10:0 of address 2.
- R4: Display-enable is high when the generator is enabled, the character count is at most the horizontal display field (bits 24:16 of address 0), and the line count is at most the vertical display field (bits 26:16 of address 2).
- R5: The horizontal sync is active for character counts from S+1 through S+W. S is bits 8:0 of address 1 and W is bits 20:16 of address 1. W = 0 gives no pulse, and characters beyond the total are never reached.
- R6: The vertical sync is active for line counts from S+1 through S+W. S is bits 10:0 of address 3 and W is bits 20:16 of address 3.
- R7: Bit 21 of address 1 (horizontal) and bit 21 of address 3 (vertical) select active-low sync when set. The inactive level is then 1, and that level is driven while the generator is stopped.
- R8: Bit 25 of the control register (address 4) enables the generator. While it is 0, all counters are held at 0, display-enable is low and both syncs sit at their inactive level.
- R9: While bit 22 of the control register is 1, writes to addresses 0 to 3 are ignored. Their readback and the output timing stay unchanged.
- R10: A write to addresses 0 to 3 reads back at once. It changes the output timing only from the first pixel of the next frame, or from the next cycle while the generator is stopped.
- R11: Address 5 is read-only. It returns the current line count in bits 26:16 with zeros elsewhere, and writes to it change nothing.
- R12: The control register keeps only bit 25, bit 22 and a pixel-depth code in bits 10:8. Its other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0..5) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| pix_in_char | output | 3 | Pixel position inside the current character |
| char_count | output | H_W | Current character along the line |
| line_count | output | V_W | Current line of the frame |
| disp_en | output | 1 | Display-enable |
| hsync | output | 1 | Horizontal sync at programmed polarity |
| vsync | output | 1 | Vertical sync at programmed polarity |

## Verification
The assertions assume the port sees at most one register access per cycle. They also assume that software never programs a total smaller than the current count. The staging-to-working transfer at frame end makes the second point hold automatically, because the counters are at zero whenever the working copy changes. The stimulus writes timing only while the generator is stopped, or during a frame whose working copy is already fixed. Every vector uses totals, display ends and sync windows inside the field widths. Sync windows that run past the total are deliberately included, because they are legal and only truncate.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

  localparam int REG_W     = 32;
  localparam int HI_LSB    = 16;
  localparam int SYNCW_W   = 5;
  localparam int POL_BIT   = 21;
  localparam int LOCK_BIT  = 22;
  localparam int EN_BIT    = 25;
  localparam int DEPTH_LSB = 8;
  localparam int DEPTH_W   = 3;
  localparam int PIX_W     = 3;
  localparam int N_TREG    = 4;

  typedef enum logic [2:0] {
    RA_HTIME = 3'd0,
    RA_HSYNC = 3'd1,
    RA_VTIME = 3'd2,
    RA_VSYNC = 3'd3,
    RA_CTRL  = 3'd4,
    RA_LINE  = 3'd5
  } reg_addr_e;

  // position lies in (start_m1, start_m1 + width]
  function automatic logic in_sync_window(input logic [15:0] pos,
                                          input logic [15:0] start_m1,
                                          input logic [SYNCW_W-1:0] width);
    logic [16:0] lo;
    logic [16:0] hi;
    lo = {1'b0, start_m1};
    hi = lo + 17'(width);
    return ({1'b0, pos} > lo) && ({1'b0, pos} <= hi);
  endfunction

  function automatic logic [REG_W-1:0] pack_ctrl(input logic en,
                                                 input logic lock,
                                                 input logic [DEPTH_W-1:0] depth);
    return {6'b0, en, 2'b0, lock, 11'b0, depth, 8'b0};
  endfunction

  function automatic logic [REG_W-1:0] pack_line(input logic [15:0] line);
    return {line, 16'h0000};
  endfunction

endpackage

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_pkg::*;
#(
  parameter int V_W = 11
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [2:0]                     addr,
  input  logic [REG_W-1:0]               wdata,
  input  logic                           frame_end,
  input  logic [V_W-1:0]                 line,
  output logic [REG_W-1:0]               rdata,
  output logic                           en,
  output logic                           locked,
  output logic [N_TREG-1:0][REG_W-1:0]   shadow_o,
  output logic [N_TREG-1:0][REG_W-1:0]   active_o
);

  logic                timing_wr_ok;
  logic                load_active;
  logic [DEPTH_W-1:0]  depth_q;

  assign timing_wr_ok = we && !locked;
  assign load_active  = !en || frame_end;

  for (genvar i = 0; i < N_TREG; i++) begin : g_treg
    logic [REG_W-1:0] stage_q;
    logic [REG_W-1:0] work_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
        work_q  <= '0;
      end else begin
        if (timing_wr_ok && addr == 3'(i)) stage_q <= wdata;
        if (load_active) work_q <= stage_q;
      end
    end
    assign shadow_o[i] = stage_q;
    assign active_o[i] = work_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      locked  <= 1'b0;
      depth_q <= '0;
    end else if (we && addr == RA_CTRL) begin
      en      <= wdata[EN_BIT];
      locked  <= wdata[LOCK_BIT];
      depth_q <= wdata[DEPTH_LSB +: DEPTH_W];
    end
  end

  always_comb begin
    case (reg_addr_e'(addr))
      RA_HTIME: rdata = shadow_o[0];
      RA_HSYNC: rdata = shadow_o[1];
      RA_VTIME: rdata = shadow_o[2];
      RA_VSYNC: rdata = shadow_o[3];
      RA_CTRL:  rdata = pack_ctrl(en, locked, depth_q);
      RA_LINE:  rdata = pack_line(16'(line));
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/crtc_counters.sv
module crtc_counters
  import crtc_pkg::*;
#(
  parameter int H_W = 9,
  parameter int V_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [H_W-1:0]   htot,
  input  logic [V_W-1:0]   vtot,
  output logic [PIX_W-1:0] hpix,
  output logic [H_W-1:0]   hchar,
  output logic [V_W-1:0]   vline,
  output logic             hwrap,
  output logic             frame_end
);

  logic char_last;

  assign char_last = (hpix == {PIX_W{1'b1}});
  assign hwrap     = en && char_last && (hchar >= htot);
  assign frame_end = hwrap && (vline >= vtot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hpix  <= '0;
      hchar <= '0;
      vline <= '0;
    end else if (!en) begin
      hpix  <= '0;
      hchar <= '0;
      vline <= '0;
    end else begin
      hpix <= hpix + 1'b1;
      if (hwrap) begin
        hchar <= '0;
        vline <= frame_end ? '0 : vline + 1'b1;
      end else if (char_last) begin
        hchar <= hchar + 1'b1;
      end
    end
  end

endmodule

// File: rtl/crtc_syncgen.sv
module crtc_syncgen
  import crtc_pkg::*;
#(
  parameter int H_W = 9,
  parameter int V_W = 11
) (
  input  logic               en,
  input  logic [H_W-1:0]     hchar,
  input  logic [V_W-1:0]     vline,
  input  logic [H_W-1:0]     hdisp,
  input  logic [V_W-1:0]     vdisp,
  input  logic [H_W-1:0]     hs_start_m1,
  input  logic [SYNCW_W-1:0] hs_width,
  input  logic               hs_low,
  input  logic [V_W-1:0]     vs_start_m1,
  input  logic [SYNCW_W-1:0] vs_width,
  input  logic               vs_low,
  output logic               de,
  output logic               hsync,
  output logic               vsync
);

  logic h_active;
  logic v_active;

  assign h_active = en && in_sync_window(16'(hchar), 16'(hs_start_m1), hs_width);
  assign v_active = en && in_sync_window(16'(vline), 16'(vs_start_m1), vs_width);

  assign de    = en && (hchar <= hdisp) && (vline <= vdisp);
  assign hsync = h_active ^ hs_low;
  assign vsync = v_active ^ vs_low;

endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
  import crtc_pkg::*;
#(
  parameter int H_W = 9,
  parameter int V_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic [2:0]       pix_in_char,
  output logic [H_W-1:0]   char_count,
  output logic [V_W-1:0]   line_count,
  output logic             disp_en,
  output logic             hsync,
  output logic             vsync
);

  logic                          gen_en;
  logic                          wr_locked;
  logic                          hwrap;
  logic                          frame_end;
  logic [N_TREG-1:0][REG_W-1:0]  shadow_w;
  logic [N_TREG-1:0][REG_W-1:0]  active_w;

  logic [H_W-1:0]     act_htot;
  logic [H_W-1:0]     act_hdisp;
  logic [H_W-1:0]     act_hss;
  logic [SYNCW_W-1:0] act_hsw;
  logic               act_hlow;
  logic [V_W-1:0]     act_vtot;
  logic [V_W-1:0]     act_vdisp;
  logic [V_W-1:0]     act_vss;
  logic [SYNCW_W-1:0] act_vsw;
  logic               act_vlow;

  assign act_htot  = active_w[RA_HTIME][H_W-1:0];
  assign act_hdisp = active_w[RA_HTIME][HI_LSB +: H_W];
  assign act_hss   = active_w[RA_HSYNC][H_W-1:0];
  assign act_hsw   = active_w[RA_HSYNC][HI_LSB +: SYNCW_W];
  assign act_hlow  = active_w[RA_HSYNC][POL_BIT];
  assign act_vtot  = active_w[RA_VTIME][V_W-1:0];
  assign act_vdisp = active_w[RA_VTIME][HI_LSB +: V_W];
  assign act_vss   = active_w[RA_VSYNC][V_W-1:0];
  assign act_vsw   = active_w[RA_VSYNC][HI_LSB +: SYNCW_W];
  assign act_vlow  = active_w[RA_VSYNC][POL_BIT];

  crtc_regfile #(.V_W(V_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .frame_end (frame_end),
    .line      (line_count),
    .rdata     (reg_rdata),
    .en        (gen_en),
    .locked    (wr_locked),
    .shadow_o  (shadow_w),
    .active_o  (active_w)
  );

  crtc_counters #(.H_W(H_W), .V_W(V_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (gen_en),
    .htot      (act_htot),
    .vtot      (act_vtot),
    .hpix      (pix_in_char),
    .hchar     (char_count),
    .vline     (line_count),
    .hwrap     (hwrap),
    .frame_end (frame_end)
  );

  crtc_syncgen #(.H_W(H_W), .V_W(V_W)) u_sync (
    .en          (gen_en),
    .hchar       (char_count),
    .vline       (line_count),
    .hdisp       (act_hdisp),
    .vdisp       (act_vdisp),
    .hs_start_m1 (act_hss),
    .hs_width    (act_hsw),
    .hs_low      (act_hlow),
    .vs_start_m1 (act_vss),
    .vs_width    (act_vsw),
    .vs_low      (act_vlow),
    .de          (disp_en),
    .hsync       (hsync),
    .vsync       (vsync)
  );

endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk
  import crtc_pkg::*;
#(
  parameter int H_W = 9,
  parameter int V_W = 11
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_we,
  input logic [2:0]                    reg_addr,
  input logic                          en,
  input logic                          locked,
  input logic [PIX_W-1:0]              hpix,
  input logic [H_W-1:0]                hchar,
  input logic [V_W-1:0]                vline,
  input logic [H_W-1:0]                act_htot,
  input logic                          hwrap,
  input logic                          frame_end,
  input logic                          disp_en,
  input logic [N_TREG-1:0][REG_W-1:0]  shadow_w,
  input logic [N_TREG-1:0][REG_W-1:0]  active_w
);

  a_r2_pix_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hpix != {PIX_W{1'b1}}) |=> (hpix == $past(hpix) + 1'b1));

  a_r2_char_bound: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (hchar <= act_htot));

  a_r3_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hwrap && !frame_end) |=> (vline == $past(vline) + 1'b1));

  a_r4_de_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> en);

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (hpix == '0 && hchar == '0 && vline == '0));

  a_r9_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr < 3'd4 && locked) |=> $stable(shadow_w));

  a_r10_frame_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_w) |-> $past(frame_end || !en));

endmodule

bind crtc_timing_gen crtc_timing_chk #(.H_W(H_W), .V_W(V_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .en        (gen_en),
  .locked    (wr_locked),
  .hpix      (pix_in_char),
  .hchar     (char_count),
  .vline     (line_count),
  .act_htot  (act_htot),
  .hwrap     (hwrap),
  .frame_end (frame_end),
  .disp_en   (disp_en),
  .shadow_w  (shadow_w),
  .active_w  (active_w)
);

// File: tb/tb_crtc_timing_gen.sv
`timescale 1ns/1ps
module tb_crtc_timing_gen;
  localparam int H_W = 9;
  localparam int V_W = 11;
  localparam logic [31:0] EN_W   = 32'h0200_0000;
  localparam logic [31:0] LOCK_W = 32'h0040_0000;
  localparam logic [31:0] CTRL_KEEP = 32'h0240_0700;

  // per vector: address 0..3 words
  localparam logic [31:0] CFG [4][4] = '{
    '{32'h0006_0009, 32'h0001_0007, 32'h0003_0005, 32'h0001_0003},
    '{32'h0004_0007, 32'h0022_0005, 32'h0002_0006, 32'h0022_0003},
    '{32'h0005_0005, 32'h0004_0004, 32'h0004_0004, 32'h0020_0000},
    '{32'h0000_0000, 32'h0001_0000, 32'h0000_0003, 32'h0001_0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0] pix_in_char;
  logic [H_W-1:0] char_count;
  logic [V_W-1:0] line_count;
  logic disp_en, hsync, vsync;

  always #10 clk = ~clk;

  crtc_timing_gen #(.H_W(H_W), .V_W(V_W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_in_char(pix_in_char),
    .char_count(char_count), .line_count(line_count), .disp_en(disp_en),
    .hsync(hsync), .vsync(vsync));

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_sh [4];
  logic [31:0] m_act [4];
  logic [31:0] m_ctrl;
  int m_hp, m_hc, m_vl;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_out();
    logic en, de, hs, vs;
    int hdisp, vdisp, hss, hsw, vss, vsw, px, st;
    en    = m_ctrl[25];
    hdisp = int'(m_act[0][24:16]);
    vdisp = int'(m_act[2][26:16]);
    hss   = int'(m_act[1][8:0]);
    hsw   = int'(m_act[1][20:16]);
    vss   = int'(m_act[3][10:0]);
    vsw   = int'(m_act[3][20:16]);
    de = en && m_hc <= hdisp && m_vl <= vdisp;
    px = m_hc * 8;
    st = (hss + 1) * 8;
    hs = (en && px >= st && px < st + hsw * 8) ? ~m_act[1][21] : m_act[1][21];
    vs = (en && m_vl >= vss + 1 && m_vl < vss + 1 + vsw) ? ~m_act[3][21] : m_act[3][21];
    return {6'b0, de, hs, vs, 3'(m_hp), 9'(m_hc), 11'(m_vl)};
  endfunction

  function automatic logic [31:0] dut_out();
    return {6'b0, disp_en, hsync, vsync, pix_in_char, char_count, line_count};
  endfunction

  // compare now, advance the model over the coming edge, move to next negedge
  task automatic cycle();
    logic en, fe;
    int htot, vtot;
    check("R2 R3 R4 R5 R6 R7 R8 timing", dut_out(), model_out());
    en   = m_ctrl[25];
    htot = int'(m_act[0][8:0]);
    vtot = int'(m_act[2][10:0]);
    fe   = en && m_hp == 7 && m_hc == htot && m_vl == vtot;
    if (!en || fe) for (int i = 0; i < 4; i++) m_act[i] = m_sh[i];
    if (!en) begin
      m_hp = 0; m_hc = 0; m_vl = 0;
    end else if (m_hp == 7) begin
      m_hp = 0;
      if (m_hc == htot) begin
        m_hc = 0;
        m_vl = (m_vl == vtot) ? 0 : m_vl + 1;
      end else m_hc++;
    end else m_hp++;
    if (reg_we) begin
      if (reg_addr < 3'd4 && !m_ctrl[22]) m_sh[reg_addr] = reg_wdata;
      else if (reg_addr == 3'd4) m_ctrl = reg_wdata & CTRL_KEEP;
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    cycle();
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string req);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic run(int n);
    for (int c = 0; c < n; c++) begin
      if (c % 37 == 5) rd(3'd5, 32'(m_vl) << 16, "R11 line readback");
      cycle();
    end
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_sh[i] = '0; m_act[i] = '0; end
    m_ctrl = '0; m_hp = 0; m_hc = 0; m_vl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) rd(3'(a), 32'h0, "R1 reset readback");
    check("R1 reset outputs", dut_out(), 32'h0);
    cycle();

    // vector table walk
    for (int k = 0; k < 4; k++) begin
      int frame;
      wr(3'd4, 32'h0);
      for (int r = 0; r < 4; r++) wr(3'(r), CFG[k][r]);
      wr(3'd4, EN_W);
      frame = (int'(CFG[k][0][8:0]) + 1) * 8 * (int'(CFG[k][2][10:0]) + 1);
      run(frame + 24);
    end

    // R10 mid-frame update lands at next frame
    wr(3'd4, 32'h0);
    for (int r = 0; r < 4; r++) wr(3'(r), CFG[0][r]);
    wr(3'd4, EN_W);
    run(100);
    wr(3'd0, 32'h0003_0009);
    rd(3'd0, 32'h0003_0009, "R10 immediate readback");
    run(960);

    // R9 lock
    wr(3'd4, EN_W | LOCK_W);
    wr(3'd0, 32'h0001_0002);
    wr(3'd1, 32'h0003_0001);
    rd(3'd0, 32'h0003_0009, "R9 locked write ignored addr0");
    rd(3'd1, CFG[0][1], "R9 locked write ignored addr1");
    run(500);

    // R12 control field storage
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, 32'h0240_0700, "R12 ctrl kept bits");
    wr(3'd4, 32'h0000_0300);
    rd(3'd4, 32'h0000_0300, "R12 depth code");

    // R8 stopped generator
    run(3);
    check("R8 idle outputs", dut_out(), 32'h0);

    // R11 write to line register ignored
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, 32'h0, "R11 line write ignored");
    rd(3'd0, 32'h0003_0009, "R11 line write leaves timing regs");

    // R7 idle level with active-low polarity
    wr(3'd1, CFG[1][1]);
    wr(3'd3, CFG[1][3]);
    run(2);
    check("R7 idle active-low level", {30'b0, hsync, vsync}, 32'h3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule